// File: doc/BRIEF.md
# Parity-Protected Status Register Bank

This block holds the read-only status registers of a serial-controlled motor driver. It takes raw fault indications, a live position count and a watchdog event from the rest of the chip. It presents them as five 8-bit registers, which the serial interface selects with a 5-bit address. Bit 7 of every register is a parity bit computed over bits 6..0, so the master can tell when a read was corrupted.

Sampling of the internal sources follows the chip-select level. While chip-select is high, meaning the bus is idle, the registers follow their sources on every system clock. While it is low, the whole bank and the error output are frozen, so a transfer always reads a consistent snapshot.

Over-current and thermal-shutdown flags are sticky. A read of their register only marks them for clearing, and the clear takes effect at the first clock edge after chip-select returns high. The watchdog-event flag is sticky too, but only a control write of 0 to the watchdog-enable bit clears it. The error output is high while any sticky flag is set.

Top module: `status_parity_bank`

## Requirements
- R1: Bit 7 of every register read is 1 when bits 6..0 contain an odd number of ones, and 0 otherwise.
- R2: After reset, every register reads zero and `err` is low. The registers are decoded at addresses 04h, 05h, 06h, 07h and 0Ah, and every other address reads 00h. `rd_data` follows `rd_addr` combinationally.
- R3: At a clock edge where `cs_n` is low, no register, flag or `err` takes a new value from the sources, so source changes during a transfer are invisible until after `cs_n` returns high.
- R4: Register 04h is live and has this layout: bit 6 thermal warning, bit 5 pump fail, bit 4 watchdog flag, bit 3 open coil X, bit 2 open coil Y, bits 1..0 zero.
- R5: Register 05h holds sticky over-current flags for bridge X in bits 6..3, with bits 2..0 zero. Register 06h holds sticky bridge-Y flags in bits 6..3 and thermal shutdown in bit 2, with bits 1..0 zero. After each edge taken while `cs_n` is high, `err` is the OR of all sticky flags and the watchdog flag.
- R6: A `rd_stb` naming 05h or 06h clears that register's flags. The clear happens at the first later edge where `cs_n` is high, not before.
- R7: The 9-bit position is shown with bits 8..2 in register 07h and bits 6..0 in register 0Ah, both live.
- R8: A watchdog event seen while `cs_n` is high sets the watchdog flag. Only `wden_wr` with `wden_val` = 0 clears it, and reading 04h does not clear it.
- R9: A fault pulse lasting one clock sets its sticky flag if `cs_n` is high at that edge. The same pulse has no effect if `cs_n` is low at that edge.
- R10: If a fault source is still active at the edge where a read clear takes effect, its flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select level; high means idle and sampling is enabled |
| src_therm_warn | input | 1 | Live thermal warning |
| src_pump_fail | input | 1 | Live charge pump failure |
| src_open_x | input | 1 | Live open coil X |
| src_open_y | input | 1 | Live open coil Y |
| src_wdog_evt | input | 1 | Watchdog time-out event |
| src_ovc_x | input | 4 | Over-current sources, bridge X |
| src_ovc_y | input | 4 | Over-current sources, bridge Y |
| src_therm_shut | input | 1 | Thermal shutdown source |
| src_pos | input | 9 | Micro-step position |
| rd_stb | input | 1 | Read strobe from the serial interface |
| rd_addr | input | 5 | Register address |
| wden_wr | input | 1 | Write strobe of the watchdog-enable bit |
| wden_val | input | 1 | Value written to watchdog-enable |
| rd_data | output | 8 | Selected register with parity in bit 7 |
| err | output | 1 | Error output |

## Verification
A stuck or lost clear-pending bit shows up on the next read of 05h or 06h once chip-select is high again: the register either stays set when its source is idle, or it clears before the bus is released. A sampling enable with the wrong polarity shows up one edge after a source changes, when a frozen register is read during a transfer. A mis-sliced position or flag shows up as a wrong value or a wrong parity bit. It appears on the first read after the single edge that loads the snapshot. The sweeps cover every position value and every live-flag combination, so any bit swap shows up within one sweep step.

// File: rtl/status_bank_pkg.sv
package status_bank_pkg;
   localparam int REG_DW = 7;

   function automatic logic [REG_DW:0] with_par(input logic [REG_DW-1:0] d);
      return {^d, d};
   endfunction
endpackage

// File: rtl/status_live_snap.sv
module status_live_snap #(
   parameter int LIVE_W = 4,
   parameter int POS_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_en,
   input  logic [LIVE_W-1:0] live_in,
   input  logic [POS_W-1:0]  pos_in,
   output logic [LIVE_W-1:0] live_q,
   output logic [POS_W-1:0]  pos_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
         pos_q  <= '0;
      end else if (smp_en) begin
         live_q <= live_in;
         pos_q  <= pos_in;
      end
   end
endmodule

// File: rtl/status_sticky_bank.sv
module status_sticky_bank #(
   parameter int FLAG_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_en,
   input  logic              rd_hit,
   input  logic [FLAG_W-1:0] src,
   output logic [FLAG_W-1:0] flags_d,
   output logic [FLAG_W-1:0] flags_q,
   output logic              pend_q
);
   always_comb begin
      if (!smp_en)     flags_d = flags_q;
      else if (pend_q) flags_d = src;
      else             flags_d = flags_q | src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         flags_q <= flags_d;
         pend_q  <= rd_hit | (pend_q & ~smp_en);
      end
   end
endmodule

// File: rtl/status_parity_bank.sv
module status_parity_bank
   import status_bank_pkg::*;
#(
   parameter int              ADDR_W = 5,
   parameter int              OVC_W  = 4,
   parameter int              POS_W  = 9,
   parameter logic [ADDR_W-1:0] A_LIVE = 5'h04,
   parameter logic [ADDR_W-1:0] A_LATX = 5'h05,
   parameter logic [ADDR_W-1:0] A_LATY = 5'h06,
   parameter logic [ADDR_W-1:0] A_POSH = 5'h07,
   parameter logic [ADDR_W-1:0] A_POSL = 5'h0A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              src_therm_warn,
   input  logic              src_pump_fail,
   input  logic              src_open_x,
   input  logic              src_open_y,
   input  logic              src_wdog_evt,
   input  logic [OVC_W-1:0]  src_ovc_x,
   input  logic [OVC_W-1:0]  src_ovc_y,
   input  logic              src_therm_shut,
   input  logic [POS_W-1:0]  src_pos,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wden_wr,
   input  logic              wden_val,
   output logic [REG_DW:0]   rd_data,
   output logic              err
);
   localparam int N_LAT  = 2;
   localparam int LIVE_W = 4;
   localparam int POS_LO = POS_W - REG_DW;

   if (OVC_W < 1 || OVC_W > REG_DW - 1) begin : g_bad_ovc
      $error("OVC_W must lie in 1..6");
   end
   if (POS_W < REG_DW || POS_W > 2 * REG_DW) begin : g_bad_pos
      $error("POS_W must lie in 7..14");
   end
   if (A_LIVE == A_LATX || A_LATX == A_LATY || A_POSH == A_POSL ||
       A_LIVE == A_POSH || A_LATY == A_POSL) begin : g_bad_addr
      $error("status addresses must be distinct");
   end

   logic                       smp_en;
   logic [LIVE_W-1:0]          live_q;
   logic [POS_W-1:0]           pos_q;
   logic [N_LAT-1:0][REG_DW-1:0] lat_src;
   logic [N_LAT-1:0][REG_DW-1:0] lat_d;
   logic [N_LAT-1:0][REG_DW-1:0] lat_q;
   logic [N_LAT-1:0]           lat_pend;
   logic                       wd_d, wd_q, err_q;

   assign smp_en     = cs_n;
   assign lat_src[0] = REG_DW'(src_ovc_x) << (REG_DW - OVC_W);
   assign lat_src[1] = REG_DW'({src_ovc_y, src_therm_shut}) << (REG_DW - 1 - OVC_W);

   status_live_snap #(.LIVE_W(LIVE_W), .POS_W(POS_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_en  (smp_en),
      .live_in ({src_therm_warn, src_pump_fail, src_open_x, src_open_y}),
      .pos_in  (src_pos),
      .live_q  (live_q),
      .pos_q   (pos_q)
   );

   for (genvar gi = 0; gi < N_LAT; gi++) begin : g_lat
      localparam logic [ADDR_W-1:0] MY_ADDR = (gi == 0) ? A_LATX : A_LATY;
      status_sticky_bank #(.FLAG_W(REG_DW)) u_lat (
         .clk     (clk),
         .rst_n   (rst_n),
         .smp_en  (smp_en),
         .rd_hit  (rd_stb && (rd_addr == MY_ADDR)),
         .src     (lat_src[gi]),
         .flags_d (lat_d[gi]),
         .flags_q (lat_q[gi]),
         .pend_q  (lat_pend[gi])
      );
   end

   always_comb begin
      if (smp_en && src_wdog_evt)  wd_d = 1'b1;
      else if (wden_wr && !wden_val) wd_d = 1'b0;
      else                         wd_d = wd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         wd_q <= wd_d;
         if (smp_en) err_q <= (|lat_d) | wd_d;
      end
   end

   assign err = err_q;

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_LIVE)
         rd_data = with_par({live_q[3:2], wd_q, live_q[1:0], 2'b00});
      else if (rd_addr == A_LATX)
         rd_data = with_par(lat_q[0]);
      else if (rd_addr == A_LATY)
         rd_data = with_par(lat_q[1]);
      else if (rd_addr == A_POSH)
         rd_data = with_par(pos_q[POS_W-1:POS_LO]);
      else if (rd_addr == A_POSL)
         rd_data = with_par(pos_q[REG_DW-1:0]);
   end
endmodule

// File: rtl/status_parity_bank_chk.sv
module status_parity_bank_chk #(
   parameter int OVC_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic [OVC_W-1:0] src_ovc_x,
   input logic             wden_wr,
   input logic             wden_val,
   input logic [7:0]       rd_data,
   input logic             err,
   input logic [1:0][6:0]  lat_q,
   input logic [1:0]       lat_pend,
   input logic             wd_q
);
   AST_PARITY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7] == ^rd_data[6:0]); // R1

   AST_FROZEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |=> $stable(err) && $stable(lat_q)); // R3

   AST_ERR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> err == ((|lat_q) | wd_q)); // R5

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n && !lat_pend[0] |=> (lat_q[0] & $past(lat_q[0])) == $past(lat_q[0])); // R5

   AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n && lat_pend[0] && (src_ovc_x == '0) |=> lat_q[0] == '0); // R6

   AST_WD_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_q) |-> $past(wden_wr && !wden_val)); // R8
endmodule

bind status_parity_bank status_parity_bank_chk #(.OVC_W(OVC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .src_ovc_x (src_ovc_x),
   .wden_wr   (wden_wr),
   .wden_val  (wden_val),
   .rd_data   (rd_data),
   .err       (err),
   .lat_q     (lat_q),
   .lat_pend  (lat_pend),
   .wd_q      (wd_q)
);

// File: tb/status_parity_bank_bench.sv
module status_parity_bank_bench;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
   logic       tw = 0, cp = 0, ox = 0, oy = 0, wde = 0, tsd = 0;
   logic [3:0] ovx = 0, ovy = 0;
   logic [8:0] pos = 0;
   logic       rd_stb = 0, wden_wr = 0, wden_val = 0;
   logic [4:0] rd_addr = 0;
   logic [7:0] rd_data;
   logic       err;
   int         n_chk = 0, n_bad = 0;
   logic [7:0] got;

   always #(CLK_PER/2) clk = ~clk;

   status_parity_bank u_status_parity_bank (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
      .src_therm_warn(tw), .src_pump_fail(cp), .src_open_x(ox), .src_open_y(oy),
      .src_wdog_evt(wde), .src_ovc_x(ovx), .src_ovc_y(ovy), .src_therm_shut(tsd),
      .src_pos(pos), .rd_stb(rd_stb), .rd_addr(rd_addr),
      .wden_wr(wden_wr), .wden_val(wden_val), .rd_data(rd_data), .err(err)
   );

   function automatic logic [7:0] wp(input logic [6:0] d);
      int ones = 0;
      for (int i = 0; i < 7; i++) ones += d[i];
      return {logic'(ones % 2), d};
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic strobe(input logic [4:0] a);
      rd_addr = a;
      rd_stb  = 1;
      tick();
      rd_stb  = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      tick(); tick();
      rst_n = 1;
      tick();

      // R2: reset state and unmapped addresses
      for (int a = 0; a < 32; a++) begin
         rd(5'(a), got);
         chk("R2 reset/decode", got, 8'h00);
      end
      chk("R2 err after reset", {7'b0, err}, 8'h00);

      // R7 and R1: sweep every position value
      for (int p = 0; p < 512; p++) begin
         pos = 9'(p);
         tick();
         rd(5'h07, got); chk("R7 R1 pos high", got, wp(pos[8:2]));
         rd(5'h0A, got); chk("R7 R1 pos low", got, wp(pos[6:0]));
      end

      // R4: every live flag combination
      for (int v = 0; v < 16; v++) begin
         {tw, cp, ox, oy} = 4'(v);
         tick();
         rd(5'h04, got);
         chk("R4 live layout", got, wp({tw, cp, 1'b0, ox, oy, 2'b00}));
      end
      {tw, cp, ox, oy} = 4'h0;
      tick();
      rd(5'h04, got); chk("R4 live follows source", got, 8'h00);

      // R3: frozen while cs_n low
      pos = 9'h155; tick();
      cs_n = 0; pos = 9'h0AA; tw = 1;
      tick(); tick(); tick();
      rd(5'h07, got); chk("R3 pos frozen", got, wp(7'(9'h155 >> 2)));
      rd(5'h04, got); chk("R3 live frozen", got, 8'h00);
      cs_n = 1; tick();
      rd(5'h07, got); chk("R3 pos after release", got, wp(7'(9'h0AA >> 2)));
      rd(5'h04, got); chk("R3 live after release", got, wp(7'h40));
      tw = 0; tick();

      // R9: pulse while cs_n low is ignored
      cs_n = 0; ovx = 4'hF; tick();
      ovx = 0; cs_n = 1; tick();
      rd(5'h05, got); chk("R9 pulse in transfer ignored", got, 8'h00);
      chk("R9 err stays low", {7'b0, err}, 8'h00);

      // R9 R5: single-cycle pulse with cs_n high latches
      ovx = 4'b1010; tick();
      ovx = 0; tick(); tick();
      rd(5'h05, got); chk("R9 R5 latched X", got, wp({4'b1010, 3'b000}));
      chk("R5 err set", {7'b0, err}, 8'h01);

      // R6: clear waits for cs_n high
      cs_n = 0; strobe(5'h05); tick();
      rd(5'h05, got); chk("R6 no clear during transfer", got, wp({4'b1010, 3'b000}));
      chk("R6 err held", {7'b0, err}, 8'h01);
      cs_n = 1; tick();
      rd(5'h05, got); chk("R6 cleared", got, 8'h00);
      chk("R6 err cleared", {7'b0, err}, 8'h00);

      // R10: active source survives clear
      ovy = 4'b0001; tsd = 1; tick();
      ovy = 0; tick();
      rd(5'h06, got); chk("R5 latched Y", got, wp({4'b0001, 1'b1, 2'b00}));
      cs_n = 0; strobe(5'h06);
      cs_n = 1; tick();
      rd(5'h06, got); chk("R10 still active re-set", got, wp({4'b0000, 1'b1, 2'b00}));
      chk("R10 err kept", {7'b0, err}, 8'h01);
      tsd = 0;
      strobe(5'h06);
      tick();
      rd(5'h06, got); chk("R6 clear in idle", got, 8'h00);
      chk("R6 err low", {7'b0, err}, 8'h00);

      // R8: watchdog flag
      cs_n = 0; wde = 1; tick();
      wde = 0; cs_n = 1; tick();
      rd(5'h04, got); chk("R8 event in transfer ignored", got, 8'h00);
      wde = 1; tick();
      wde = 0; tick();
      rd(5'h04, got); chk("R8 wd set", got, wp(7'h10));
      chk("R8 err set", {7'b0, err}, 8'h01);
      strobe(5'h04); tick();
      rd(5'h04, got); chk("R8 read does not clear", got, wp(7'h10));
      wden_wr = 1; wden_val = 1; tick();
      wden_wr = 0;
      rd(5'h04, got); chk("R8 write 1 keeps", got, wp(7'h10));
      wden_wr = 1; wden_val = 0; tick();
      wden_wr = 0;
      rd(5'h04, got); chk("R8 write 0 clears", got, 8'h00);
      chk("R8 err cleared", {7'b0, err}, 8'h00);

      summary();
   end
endmodule